// File: doc/BRIEF.md
# Dual-Sequence ADC Conversion Controller

This block is the digital side of a multi-channel analog-to-digital converter that two independent conversion sequences, A and B, share. Software programs each sequence with a control word that has a channel mask, a trigger choice and the run modes. A sequence starts when software writes a start bit, when an edge arrives on a selected hardware trigger line, or when burst mode re-arms it without a trigger. Once started, the sequence walks its selected channels from the lowest to the highest. For each channel it issues one request to an abstract converter port, which answers later with a result.

Each result is stored in two places: a per-channel data slot and the owning sequence's global data slot. Both slots carry a valid flag and an overrun flag, and reading a slot clears them. A shared flags word collects the overrun events and the per-sequence interrupt events; software writes 1 to a flag to clear it. When both sequences want the converter in the same cycle, a per-sequence priority bit decides which one goes first. Only one conversion is ever outstanding.

Top module: `adc_dual_sequencer`

## Requirements
- R1: After reset, every control, data and flags word reads 0 and no conversion request is made.
- R2: A control word (sequence A at word address 0, sequence B at 1) reads back as written, except that bits 25:20 and the start bit 26 always read 0.
- R3: Writing a control word with enable (bit 31), start (bit 26) and a non-zero channel mask (bits 11:0) converts each selected channel exactly once, in ascending channel order.
- R4: Each result is stored in the channel's slot (word address 16+channel) and in the sequence's global slot (word address 2 for A, 3 for B). The stored word has valid in bit 31, overrun in bit 30, the channel in bits 29:26 and the result in bits 15:4; all other bits are 0.
- R5: A read strobe on a data slot clears that slot's valid and overrun bits.
- R6: A result written into a slot whose valid bit is still set sets that slot's overrun bit. It also sets flags bit 12+channel (channel slot) or flags bit 24+sequence (global slot).
- R7: The flags word is at word address 4. Writing a 1 to a bit clears that bit, and writing a 0 leaves it unchanged.
- R8: With bit 30 set, the sequence's interrupt flag (bit 28 for A, 29 for B) is set only when the last selected channel completes.
- R9: With bit 30 clear, the sequence's interrupt flag is set after every conversion.
- R10: With single-step (bit 28) set, each trigger converts only the next selected channel. The interrupt flag in end-of-sequence mode is set after the highest selected channel.
- R11: Bits 17:12 select the hardware trigger line. Bit 18 set means the rising edge is active, and bit 18 clear means the falling edge is active. Bit 19 set skips the two-stage synchroniser.
- R12: While a sequence's enable bit is 0, neither start writes nor hardware edges start a conversion.
- R13: While burst (bit 27) is set, the sequence restarts by itself after each completion. After burst is cleared, the sequence in flight finishes and no new one starts.
- R14: When both sequences are waiting, the sequence whose bit 29 is set, while the other's is not, is served first; otherwise A is served first. A new request is issued only after the previous conversion has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Read strobe; clears the status of the data slot addressed |
| reg_addr | input | 5 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| hw_trig | input | NTRIG | Hardware trigger lines |
| conv_req | output | 1 | One-cycle conversion request |
| conv_chan | output | 4 | Channel to convert, valid with conv_req |
| conv_done | input | 1 | One-cycle completion of the outstanding conversion |
| conv_result | input | 12 | Result, valid with conv_done |

## Verification
Some rules are checked by assertions on every cycle. No two back-to-back requests are issued. A completion never arrives without an outstanding request. A slot's overrun bit is never set without its valid bit. A disabled sequence holds no pending or active state. Single-step never re-arms itself after a conversion. The bench scenarios are needed for the behaviour that only shows over a whole run: the ascending order of conversions across a sweep of channel masks, the exact stored words, the interrupt timing in end-of-conversion and end-of-sequence mode, the edge polarity and sync bypass, the burst stop point, and which sequence wins a simultaneous trigger.

// File: rtl/adcs_pkg.sv
// Shared constants for the dual-sequence ADC controller.
// Assumes a 12-bit converter result and at most 12 channels.
package adcs_pkg;
    localparam int RES_W = 12;
    localparam int CH_W  = 4;

    // control word field positions
    localparam int F_SRC_LO = 12;
    localparam int F_SRC_HI = 17;
    localparam int F_POL    = 18;
    localparam int F_BYP    = 19;
    localparam int F_START  = 26;
    localparam int F_BURST  = 27;
    localparam int F_STEP   = 28;
    localparam int F_PRI    = 29;
    localparam int F_EOS    = 30;
    localparam int F_EN     = 31;

    // bits kept in a control register (20..26 read as zero)
    localparam logic [31:0] CTRL_KEEP = 32'hF80F_FFFF;

    // flags word layout
    localparam int FL_CH_OVR  = 12;
    localparam int FL_SEQ_OVR = 24;
    localparam int FL_SEQ_INT = 28;

    // word addresses
    localparam logic [4:0] A_CTRL_A = 5'd0;
    localparam logic [4:0] A_CTRL_B = 5'd1;
    localparam logic [4:0] A_GLB_A  = 5'd2;
    localparam logic [4:0] A_GLB_B  = 5'd3;
    localparam logic [4:0] A_FLAGS  = 5'd4;
    localparam logic [4:0] A_CHAN0  = 5'd16;

    // pack a stored result into its register word
    function automatic logic [31:0] slot_word(input logic vld, input logic ovr,
                                              input logic [CH_W-1:0] ch,
                                              input logic [RES_W-1:0] res);
        return {vld, ovr, ch, 10'b0, res, 4'b0};
    endfunction
endpackage

// File: rtl/adcs_trig_edge.sv
// Hardware trigger edge detector for one sequence.
// Picks one line out of NTRIG, optionally passes it through a two-flop
// synchroniser, and pulses edge_o for one cycle on the chosen polarity.
// Assumes a select value beyond NTRIG-1 means "no trigger".
module adcs_trig_edge #(
    parameter int NTRIG = 8,
    parameter int SW    = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NTRIG-1:0] trig_i,
    input  logic [SW-1:0]    sel_i,
    input  logic             rising_i,
    input  logic             bypass_i,
    output logic             edge_o
);
    logic [NTRIG-1:0] s1_q, s2_q;
    logic             pick, prev_q;

    // two-stage synchroniser on every line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= trig_i;
            s2_q <= s1_q;
        end
    end

    // select the programmed line, raw or synchronised
    always_comb begin
        pick = 1'b0;
        for (int i = 0; i < NTRIG; i++) begin
            if (sel_i == SW'(i)) pick = bypass_i ? trig_i[i] : s2_q[i];
        end
    end

    // remember the previous level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= pick;
    end

    assign edge_o = rising_i ? (pick & ~prev_q) : (~pick & prev_q);
endmodule

// File: rtl/adcs_seq_walk.sv
// One conversion sequence: holds its control register, accepts triggers,
// walks the channel mask in ascending order and raises a request per step.
// Assumes the arbiter grants only while it has no conversion outstanding
// and routes done_i only to the sequence owning that conversion.
module adcs_seq_walk
    import adcs_pkg::*;
#(
    parameter int NCH = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_i,
    input  logic [31:0]     wdata_i,
    input  logic            hw_edge_i,
    input  logic            gnt_i,
    input  logic            done_i,
    output logic [31:0]     ctrl_o,
    output logic            want_o,
    output logic [CH_W-1:0] chan_o,
    output logic            eoc_o,
    output logic            eos_o
);
    logic [31:0]     ctrl_q;
    logic            active_q, want_q, busy_q;
    logic [CH_W-1:0] ptr_q;
    logic [NCH-1:0]  st_mask;
    logic            en_next, sw_go, hw_go, burst_go, go;
    logic            next_found, first_found;
    logic [CH_W-1:0] next_ch, first_ch;

    assign st_mask  = wr_i ? wdata_i[NCH-1:0] : ctrl_q[NCH-1:0];
    assign en_next  = wr_i ? wdata_i[F_EN] : ctrl_q[F_EN];
    assign sw_go    = wr_i & wdata_i[F_START] & wdata_i[F_EN];
    assign hw_go    = ctrl_q[F_EN] & hw_edge_i;
    assign burst_go = ctrl_q[F_EN] & ctrl_q[F_BURST] & ~active_q & ~busy_q;
    assign go       = sw_go | hw_go | burst_go;

    // lowest selected channel above the current one, and lowest overall
    always_comb begin
        next_found  = 1'b0;
        next_ch     = '0;
        first_found = 1'b0;
        first_ch    = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (ctrl_q[i] && i > int'(ptr_q)) begin
                next_found = 1'b1;
                next_ch    = CH_W'(i);
            end
            if (st_mask[i]) begin
                first_found = 1'b1;
                first_ch    = CH_W'(i);
            end
        end
    end

    // control register and walk state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            active_q <= 1'b0;
            want_q   <= 1'b0;
            busy_q   <= 1'b0;
            ptr_q    <= '0;
        end else begin
            if (wr_i) ctrl_q <= wdata_i & CTRL_KEEP;
            if (gnt_i) begin
                want_q <= 1'b0;
                busy_q <= 1'b1;
            end
            if (done_i) begin
                busy_q <= 1'b0;
                if (active_q) begin
                    if (next_found) begin
                        ptr_q  <= next_ch;
                        want_q <= ~ctrl_q[F_STEP];
                    end else begin
                        active_q <= 1'b0;
                    end
                end
            end
            if (go) begin
                if (!active_q && first_found) begin
                    active_q <= 1'b1;
                    ptr_q    <= first_ch;
                    want_q   <= 1'b1;
                end else if (active_q && ctrl_q[F_STEP] && !want_q && !busy_q) begin
                    want_q <= 1'b1;
                end
            end
            if (!en_next) begin
                active_q <= 1'b0;
                want_q   <= 1'b0;
            end
        end
    end

    assign ctrl_o = ctrl_q;
    assign want_o = want_q;
    assign chan_o = ptr_q;
    assign eoc_o  = done_i;
    assign eos_o  = done_i & active_q & ~next_found;

    // R12: a disabled sequence holds nothing pending or in progress
    p_off_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[F_EN] |-> (!want_q && !active_q));

    // R10: in single-step mode a finished conversion does not re-arm
    p_step_pause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && ctrl_q[F_STEP]) |=> !want_q);
endmodule

// File: rtl/adcs_slot_bank.sv
// Bank of N result slots, each with valid and overrun status.
// A write stores channel and result, setting overrun when the slot is still
// valid; a read-clear drops valid and overrun. A write wins over a clear.
// Assumes wr_idx_i is below N whenever wr_i is high.
module adcs_slot_bank
    import adcs_pkg::*;
#(
    parameter int N  = 12,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [IW-1:0]    wr_idx_i,
    input  logic [CH_W-1:0]  wr_chan_i,
    input  logic [RES_W-1:0] wr_res_i,
    input  logic             clr_i,
    input  logic [IW-1:0]    rd_idx_i,
    output logic [31:0]      rd_word_o,
    output logic             ovr_hit_o
);
    logic [N-1:0]     valid_q, ovr_q;
    logic [CH_W-1:0]  chan_q [N];
    logic [RES_W-1:0] res_q  [N];
    logic             same_clr;

    assign same_clr  = clr_i && (rd_idx_i == wr_idx_i);
    assign ovr_hit_o = wr_i & valid_q[wr_idx_i] & ~same_clr;

    for (genvar i = 0; i < N; i++) begin : g_slot
        // store a result or clear status on read
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[i] <= 1'b0;
                ovr_q[i]   <= 1'b0;
                chan_q[i]  <= '0;
                res_q[i]   <= '0;
            end else if (wr_i && wr_idx_i == IW'(i)) begin
                valid_q[i] <= 1'b1;
                ovr_q[i]   <= valid_q[i] & ~same_clr;
                chan_q[i]  <= wr_chan_i;
                res_q[i]   <= wr_res_i;
            end else if (clr_i && rd_idx_i == IW'(i)) begin
                valid_q[i] <= 1'b0;
                ovr_q[i]   <= 1'b0;
            end
        end

        // R6: overrun can only be flagged on a slot holding valid data
        p_ovr_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
            ovr_q[i] |-> valid_q[i]);
    end

    // read mux; indices past N read as zero
    always_comb begin
        rd_word_o = '0;
        for (int i = 0; i < N; i++) begin
            if (rd_idx_i == IW'(i)) rd_word_o = slot_word(valid_q[i], ovr_q[i], chan_q[i], res_q[i]);
        end
    end
endmodule

// File: rtl/adc_dual_sequencer.sv
// Dual-sequence ADC controller top. Two sequence walkers share one
// converter through a priority arbiter; results land in per-channel and
// per-sequence slots, events in a write-1-to-clear flags word.
// Assumes NCH <= 12, one conversion outstanding, conv_done one cycle wide.
module adc_dual_sequencer
    import adcs_pkg::*;
#(
    parameter int NCH   = 12,
    parameter int NTRIG = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [4:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic [NTRIG-1:0] hw_trig,
    output logic             conv_req,
    output logic [CH_W-1:0]  conv_chan,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_result
);
    localparam int NSEQ = 2;
    localparam int CIW  = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int SW   = F_SRC_HI - F_SRC_LO + 1;

    logic [31:0]     ctrl  [NSEQ];
    logic [CH_W-1:0] chan  [NSEQ];
    logic [NSEQ-1:0] want, gnt, done, eoc, eos, hw_edge;
    logic            busy_q, owner_q, pick_b, fin;
    logic [CH_W-1:0] fin_ch;
    logic [31:0]     flags_q, flags_set;
    logic [31:0]     ch_word, gl_word;
    logic            ch_ovr, gl_ovr;

    for (genvar s = 0; s < NSEQ; s++) begin : g_seq
        adcs_trig_edge #(.NTRIG(NTRIG), .SW(SW)) u_edge (
            .clk      (clk),
            .rst_n    (rst_n),
            .trig_i   (hw_trig),
            .sel_i    (ctrl[s][F_SRC_HI:F_SRC_LO]),
            .rising_i (ctrl[s][F_POL]),
            .bypass_i (ctrl[s][F_BYP]),
            .edge_o   (hw_edge[s])
        );
        adcs_seq_walk #(.NCH(NCH)) u_walk (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_i      (reg_wr && reg_addr == 5'(s)),
            .wdata_i   (reg_wdata),
            .hw_edge_i (hw_edge[s]),
            .gnt_i     (gnt[s]),
            .done_i    (done[s]),
            .ctrl_o    (ctrl[s]),
            .want_o    (want[s]),
            .chan_o    (chan[s]),
            .eoc_o     (eoc[s]),
            .eos_o     (eos[s])
        );
        assign done[s] = conv_done & busy_q & (owner_q == 1'(s));
    end

    // arbitration: B only when A idle or B alone holds priority
    assign pick_b    = want[1] & (~want[0] | (ctrl[1][F_PRI] & ~ctrl[0][F_PRI]));
    assign gnt[1]    = ~busy_q & pick_b;
    assign gnt[0]    = ~busy_q & want[0] & ~pick_b;
    assign conv_req  = |gnt;
    assign conv_chan = gnt[1] ? chan[1] : chan[0];

    // track the outstanding conversion and its owner
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            owner_q <= 1'b0;
        end else if (conv_req) begin
            busy_q  <= 1'b1;
            owner_q <= gnt[1];
        end else if (conv_done) begin
            busy_q  <= 1'b0;
        end
    end

    assign fin    = conv_done & busy_q;
    assign fin_ch = chan[owner_q];

    adcs_slot_bank #(.N(NCH)) u_chan_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (fin),
        .wr_idx_i  (CIW'(fin_ch)),
        .wr_chan_i (fin_ch),
        .wr_res_i  (conv_result),
        .clr_i     (reg_rd & reg_addr[4]),
        .rd_idx_i  (CIW'(reg_addr - A_CHAN0)),
        .rd_word_o (ch_word),
        .ovr_hit_o (ch_ovr)
    );

    adcs_slot_bank #(.N(NSEQ)) u_glob_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (fin),
        .wr_idx_i  (owner_q),
        .wr_chan_i (fin_ch),
        .wr_res_i  (conv_result),
        .clr_i     (reg_rd && (reg_addr == A_GLB_A || reg_addr == A_GLB_B)),
        .rd_idx_i  (reg_addr[0]),
        .rd_word_o (gl_word),
        .ovr_hit_o (gl_ovr)
    );

    // events raised this cycle
    always_comb begin
        flags_set = '0;
        for (int i = 0; i < NCH; i++) begin
            if (ch_ovr && fin_ch == CH_W'(i)) flags_set[FL_CH_OVR + i] = 1'b1;
        end
        for (int s = 0; s < NSEQ; s++) begin
            if (gl_ovr && owner_q == 1'(s)) flags_set[FL_SEQ_OVR + s] = 1'b1;
            if (ctrl[s][F_EOS] ? eos[s] : eoc[s]) flags_set[FL_SEQ_INT + s] = 1'b1;
        end
    end

    // flags: set wins over a write-1 clear
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else if (reg_wr && reg_addr == A_FLAGS) flags_q <= (flags_q & ~reg_wdata) | flags_set;
        else flags_q <= flags_q | flags_set;
    end

    // register read mux
    always_comb begin
        case (reg_addr)
            A_CTRL_A: reg_rdata = ctrl[0];
            A_CTRL_B: reg_rdata = ctrl[1];
            A_GLB_A,
            A_GLB_B:  reg_rdata = gl_word;
            A_FLAGS:  reg_rdata = flags_q;
            default:  reg_rdata = reg_addr[4] ? ch_word : '0;
        endcase
    end

    // R14: one conversion at a time, so requests never come back to back
    p_req_spacing_r14: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |=> !conv_req);

    // R14: a completion only ever answers an outstanding request
    p_done_owned_r14: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |-> busy_q);
endmodule

// File: tb/test_adc_dual_sequencer.sv
module test_adc_dual_sequencer;
    localparam int NCH   = 12;
    localparam int NTRIG = 8;
    localparam int LOGN  = 1024;
    localparam logic [31:0] EN = 32'h8000_0000, EOS = 32'h4000_0000, PRI = 32'h2000_0000,
                            STEP = 32'h1000_0000, BURST = 32'h0800_0000, START = 32'h0400_0000,
                            BYP = 32'h0008_0000, POL = 32'h0004_0000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [4:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic [NTRIG-1:0] hw_trig = '0;
    logic conv_req, conv_done = 1'b0;
    logic [3:0] conv_chan;
    logic [11:0] conv_result = '0;

    int n_vec = 0, n_bad = 0, n_conv = 0;
    bit finished = 1'b0;
    logic [3:0]  log_ch  [LOGN];
    logic [11:0] log_res [LOGN];

    always #10 clk = ~clk;

    adc_dual_sequencer #(.NCH(NCH), .NTRIG(NTRIG)) i_adc_dual_sequencer (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hw_trig(hw_trig),
        .conv_req(conv_req), .conv_chan(conv_chan), .conv_done(conv_done),
        .conv_result(conv_result)
    );

    // converter model: answers three cycles after each request, logs it
    initial begin
        forever begin
            @(negedge clk);
            conv_done = 1'b0;
            if (conv_req) begin
                logic [3:0] ch;
                logic [11:0] r;
                ch = conv_chan;
                r  = 12'((int'(ch) * 273 + n_conv * 41 + 5));
                repeat (3) @(negedge clk);
                if (n_conv < LOGN) begin
                    log_ch[n_conv]  = ch;
                    log_res[n_conv] = r;
                end
                n_conv++;
                conv_result = r;
                conv_done   = 1'b1;
            end
        end
    end

    function automatic logic [31:0] mk(input logic v, input logic o, input int ch, input logic [11:0] r);
        return {v, o, 4'(ch), 10'b0, r, 4'b0};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [4:0] a, input logic clr, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = clr;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_flag(input int bitn, output logic [31:0] d);
        for (int k = 0; k < 300; k++) begin
            rd_reg(5'd4, 1'b0, d);
            if (d[bitn]) break;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
    end

    initial begin
        logic [31:0] d;
        int base, c1;
        bit ok;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 5; a++) begin
            rd_reg(5'(a), 1'b0, d);
            check(d == 0, "R1 reset word", d, 0);
        end
        rd_reg(5'd16, 1'b0, d);
        check(d == 0 && !conv_req, "R1 reset channel slot / request", d, 0);

        // R2: readback with reserved bits and start reading zero (R12: enable 0, no run)
        wr_reg(5'd1, 32'h7FFF_FFFF);
        rd_reg(5'd1, 1'b0, d);
        check(d == 32'h780F_FFFF, "R2 control readback", d, 32'h780F_FFFF);
        idle(20);
        check(n_conv == 0, "R12 disabled burst/start idle", n_conv, 0);
        wr_reg(5'd1, 32'h0);

        // R3/R4/R8: software start over a sweep of channel masks
        for (int i = 0; i < 43; i++) begin
            logic [11:0] m;
            int h, pc, idx;
            m = (i < 40) ? 12'(i * 755 + 1) : (i == 40) ? 12'hFFF : (i == 41) ? 12'h800 : 12'h001;
            wr_reg(5'd4, 32'hFFFF_FFFF);
            base = n_conv;
            wr_reg(5'd0, EN | EOS | START | 32'(m));
            wait_flag(28, d);
            idle(3);
            check(d[28], "R8 end-of-sequence flag", d, 32'h1000_0000);
            ok = 1'b1; idx = base; h = 0; pc = 0;
            for (int c = 0; c < NCH; c++) begin
                if (m[c]) begin
                    if (log_ch[idx] != 4'(c)) ok = 1'b0;
                    idx++; h = c; pc++;
                end
            end
            check(ok && n_conv == idx, "R3 ascending order", n_conv, idx);
            rd_reg(5'd2, 1'b1, d);
            check(d == mk(1'b1, pc > 1, h, log_res[idx-1]), "R4 global slot word", d,
                  mk(1'b1, pc > 1, h, log_res[idx-1]));
            rd_reg(5'(16 + h), 1'b1, d);
            check((d & 32'hBFFF_FFFF) == mk(1'b1, 1'b0, h, log_res[idx-1]), "R4 channel slot word", d,
                  mk(1'b1, 1'b0, h, log_res[idx-1]));
        end

        // R5: slot just read (channel 0) now shows no valid or overrun
        rd_reg(5'd16, 1'b0, d);
        check(d[31:30] == 2'b00, "R5 read clears status", d, {2'b00, d[29:0]});

        // R6/R7: overrun on channel 3 and on global A
        wr_reg(5'd4, 32'hFFFF_FFFF);
        rd_reg(5'd19, 1'b1, d);
        rd_reg(5'd2, 1'b1, d);
        wr_reg(5'd0, EN | EOS | START | 32'h008);
        wait_flag(28, d);
        wr_reg(5'd4, 32'h1000_0000);
        wr_reg(5'd0, EN | EOS | START | 32'h008);
        wait_flag(28, d);
        idle(2);
        rd_reg(5'd4, 1'b0, d);
        check(d[15] && d[24], "R6 overrun flags", d & 32'h0100_8000, 32'h0100_8000);
        rd_reg(5'd19, 1'b0, d);
        check(d[31:30] == 2'b11, "R6 slot overrun bit", d[31:30], 2'b11);
        wr_reg(5'd4, 32'h0100_8000);
        rd_reg(5'd4, 1'b0, d);
        check(!d[15] && !d[24] && d[28], "R7 write-one clear", d, 32'h1000_0000);

        // R8 vs R9: flag timing after the first of three conversions
        for (int mode = 0; mode < 2; mode++) begin
            wr_reg(5'd4, 32'hFFFF_FFFF);
            base = n_conv;
            wr_reg(5'd0, EN | START | (mode == 0 ? EOS : 32'h0) | 32'h00E);
            while (n_conv < base + 1) @(negedge clk);
            idle(2);
            rd_reg(5'd4, 1'b0, d);
            if (mode == 0) check(!d[28], "R8 no flag mid-sequence", d[28], 0);
            else           check(d[28], "R9 flag after each conversion", d[28], 1);
            while (n_conv < base + 3) @(negedge clk);
            idle(6);
        end

        // R10: single step over channels 0,5,7
        wr_reg(5'd4, 32'hFFFF_FFFF);
        base = n_conv;
        for (int st = 0; st < 3; st++) begin
            wr_reg(5'd0, EN | EOS | STEP | START | 32'h0A1);
            idle(30);
            rd_reg(5'd4, 1'b0, d);
            check(n_conv == base + st + 1 && log_ch[base+st] == (st == 0 ? 4'd0 : st == 1 ? 4'd5 : 4'd7),
                  "R10 one channel per trigger", n_conv, base + st + 1);
            check(d[28] == (st == 2), "R10 flag only after last step", d[28], st == 2);
        end
        wr_reg(5'd0, 32'h0);

        // R11: rising edge, synchronised, line 5 on sequence B
        wr_reg(5'd4, 32'hFFFF_FFFF);
        wr_reg(5'd1, EN | EOS | POL | (32'd5 << 12) | 32'h010);
        base = n_conv;
        @(negedge clk) hw_trig[5] = 1'b1;
        idle(30);
        rd_reg(5'd4, 1'b0, d);
        check(n_conv == base + 1 && log_ch[base] == 4'd4 && d[29], "R11 rising edge trigger", n_conv, base + 1);
        @(negedge clk) hw_trig[5] = 1'b0;
        idle(30);
        check(n_conv == base + 1, "R11 falling edge ignored in rising mode", n_conv, base + 1);
        // falling edge, sync bypassed
        wr_reg(5'd1, EN | EOS | BYP | (32'd5 << 12) | 32'h010);
        @(negedge clk) hw_trig[5] = 1'b1;
        idle(30);
        check(n_conv == base + 1, "R11 rising edge ignored in falling mode", n_conv, base + 1);
        @(negedge clk) hw_trig[5] = 1'b0;
        idle(30);
        check(n_conv == base + 2, "R11 falling edge bypass trigger", n_conv, base + 2);
        wr_reg(5'd1, 32'h0);

        // R12: disabled sequence ignores hardware edge and start
        wr_reg(5'd0, POL | (32'd5 << 12) | 32'h002);
        base = n_conv;
        @(negedge clk) hw_trig[5] = 1'b1;
        idle(20);
        wr_reg(5'd0, START | POL | (32'd5 << 12) | 32'h002);
        idle(20);
        check(n_conv == base, "R12 disabled ignores triggers", n_conv, base);
        @(negedge clk) hw_trig[5] = 1'b0;

        // R14: simultaneous trigger, B has priority
        wr_reg(5'd0, EN | EOS | POL | 32'h002);
        wr_reg(5'd1, EN | EOS | PRI | POL | 32'h004);
        base = n_conv;
        @(negedge clk) hw_trig[0] = 1'b1;
        idle(40);
        check(n_conv == base + 2 && log_ch[base] == 4'd2 && log_ch[base+1] == 4'd1,
              "R14 priority sequence first", log_ch[base], 2);
        wr_reg(5'd1, EN | EOS | POL | 32'h004);
        @(negedge clk) hw_trig[0] = 1'b0;
        idle(5);
        base = n_conv;
        @(negedge clk) hw_trig[0] = 1'b1;
        idle(40);
        check(n_conv == base + 2 && log_ch[base] == 4'd1 && log_ch[base+1] == 4'd2,
              "R14 tie goes to A", log_ch[base], 1);
        @(negedge clk) hw_trig[0] = 1'b0;
        wr_reg(5'd0, 32'h0);
        wr_reg(5'd1, 32'h0);

        // R13: burst on channels 3,4 then stop
        base = n_conv;
        wr_reg(5'd0, EN | BURST | 32'h018);
        idle(80);
        wr_reg(5'd0, EN | 32'h018);
        idle(25);
        c1 = n_conv;
        ok = ((c1 - base) % 2 == 0);
        for (int k = 0; k < c1 - base; k++) begin
            if (log_ch[base+k] != ((k % 2) ? 4'd4 : 4'd3)) ok = 1'b0;
        end
        check(ok && c1 - base >= 6, "R13 burst repeats whole sequences", c1 - base, 6);
        idle(40);
        check(n_conv == c1, "R13 burst stops after clear", n_conv, c1);

        summary();
    end
endmodule